// File: doc/BRIEF.md
# IPv4 Authentication-Header Ingress Classifier

This block watches the head of every datagram that arrives on a 32-bit word stream framed by start and end markers. It reads the first five header words and issues one verdict per packet. The verdict is one of three: discard the packet, pass it on untouched, or send it to the authentication-header engine. A protect verdict also carries the statically configured encapsulation mode, which is either transport or tunnel. The block does not modify headers and does no hashing. It only decides.

Several checks feed the verdict, in a fixed order. First comes a version check on the leading nibble. Next, a packet that already carries an authentication header (protocol number 51) is recognised and waved through, so it is not protected twice. Last comes a small table of address rules, evaluated in index order. Each rule compares either the source or the destination address under a mask, and the first enabled rule that matches supplies the action. If no rule matches, a default action applies. The header is assumed to be five words long: the protocol is byte 9 and the addresses are bytes 12 to 19.

Top module: `ah_ingress_classifier`

## Requirements
- R1: When the upper nibble of the first packet word (`in_data[31:28]`) is not 4, the verdict is drop (code 0), whatever the other fields are.
- R2: For a version-4 packet whose protocol byte (third word, bits 23:16) equals 51, the verdict is bypass (code 1), regardless of any rule.
- R3: Rule i matches when `rule_en[i]` is 1 and `((addr ^ net_i) & mask_i) == 0`. Here `addr` is the destination (fifth word) when `rule_on_dst[i]` is 1, and the source (fourth word) otherwise. A disabled rule never matches.
- R4: When several rules match, the action of the lowest-indexed matching rule is used.
- R5: When no enabled rule matches, `cfg_default` supplies the action.
- R6: Action codes are 0 drop, 1 bypass, 2 protect. Code 3, whether it comes from a rule or from the default, yields a drop verdict. The output `verdict_code` is never 3.
- R7: `verdict_tunnel` equals `cfg_tunnel` (as sampled with the fifth word) when the verdict is protect, and is 0 otherwise.
- R8: `verdict_valid` rises in the cycle after the fifth accepted beat of a packet. From then on, the verdict stays unchanged through the cycle that follows the accepted end-of-packet beat. After that cycle, `verdict_valid` is low.
- R9: A packet whose end-of-packet beat comes before its fifth word produces no verdict.
- R10: Cycles with `in_valid` low are not counted as words. Beats that arrive outside a packet (after an end and before the next start) are ignored.
- R11: During and after reset, `verdict_valid` and `verdict_tunnel` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream beat is present |
| in_sop | input | 1 | Beat is the first word of a packet |
| in_eop | input | 1 | Beat is the last word of a packet |
| in_data | input | 32 | Stream word, first byte in bits 31:24 |
| cfg_tunnel | input | 1 | 1 selects tunnel mode, 0 transport mode |
| cfg_default | input | 2 | Action when no rule matches |
| rule_en | input | RULES | Per-rule enable |
| rule_on_dst | input | RULES | Per-rule address select: 1 destination, 0 source |
| rule_net | input | RULES*32 | Per-rule network value, rule i in bits 32i+31:32i |
| rule_mask | input | RULES*32 | Per-rule compare mask |
| rule_act | input | RULES*2 | Per-rule action, rule i in bits 2i+1:2i |
| verdict_valid | output | 1 | Verdict for the current packet is available |
| verdict_code | output | 2 | 0 drop, 1 bypass, 2 protect |
| verdict_tunnel | output | 1 | Protect verdict uses tunnel mode |

## Verification
Directed packets set the version, the protocol byte and the rule table against one another. A bad version paired with a protect-worthy address must still drop. An already-protected packet whose source hits a drop rule must still bypass. Two overlapping rules with different actions show whether priority follows the index. A disabled catch-all rule, and action code 3 in both a rule and the default, separate enable handling and code folding from plain matching.

Random packets mix lengths from three to twelve words, idle gaps between beats, and address values drawn inside and outside rule prefixes. The random cases also change the rule table and the mode between groups of packets. These cases exercise beat counting and hold timing across many framings. Packets ending before the fifth word, and stray beats with no start marker, show whether framing errors can produce a verdict.

// File: rtl/ah_ingress_classifier.sv
module ah_ingress_classifier #(
  parameter int RULES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [31:0]        in_data,
  input  logic               cfg_tunnel,
  input  logic [1:0]         cfg_default,
  input  logic [RULES-1:0]   rule_en,
  input  logic [RULES-1:0]   rule_on_dst,
  input  logic [RULES*32-1:0] rule_net,
  input  logic [RULES*32-1:0] rule_mask,
  input  logic [RULES*2-1:0] rule_act,
  output logic               verdict_valid,
  output logic [1:0]         verdict_code,
  output logic               verdict_tunnel
);

  localparam logic [1:0] ACT_DROP = 2'd0;
  localparam logic [1:0] ACT_PASS = 2'd1;
  localparam logic [1:0] ACT_PROT = 2'd2;
  localparam logic [7:0] PROTO_AH = 8'd51;

  logic        in_pkt, ver_ok, is_ah, fin;
  logic [2:0]  idx;
  logic [31:0] src_q;
  logic [RULES-1:0] hit;
  logic [1:0]  pick, code_n;

  wire       take = in_valid && (in_sop || in_pkt);
  wire [2:0] pos  = in_sop ? 3'd0 : idx;

  for (genvar g = 0; g < RULES; g++) begin : g_rule
    wire [31:0] addr = rule_on_dst[g] ? in_data : src_q;
    assign hit[g] = rule_en[g] &&
                    (((addr ^ rule_net[g*32 +: 32]) & rule_mask[g*32 +: 32]) == 32'd0);
  end

  always_comb begin
    pick = cfg_default;
    for (int i = RULES - 1; i >= 0; i--)
      if (hit[i]) pick = rule_act[i*2 +: 2];
  end

  assign code_n = !ver_ok         ? ACT_DROP :
                  is_ah           ? ACT_PASS :
                  (pick == 2'd3)  ? ACT_DROP : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt         <= 1'b0;
      idx            <= 3'd0;
      ver_ok         <= 1'b0;
      is_ah          <= 1'b0;
      src_q          <= 32'd0;
      fin            <= 1'b0;
      verdict_valid  <= 1'b0;
      verdict_code   <= ACT_DROP;
      verdict_tunnel <= 1'b0;
    end else begin
      if (take) begin
        in_pkt <= !in_eop;
        idx    <= in_eop ? 3'd0 : (pos == 3'd5 ? 3'd5 : pos + 3'd1);
        case (pos)
          3'd0: ver_ok <= (in_data[31:28] == 4'd4);
          3'd2: is_ah  <= (in_data[23:16] == PROTO_AH);
          3'd3: src_q  <= in_data;
          default: ;
        endcase
      end
      if (take && pos == 3'd4) begin
        verdict_valid  <= 1'b1;
        verdict_code   <= code_n;
        verdict_tunnel <= cfg_tunnel && (code_n == ACT_PROT);
        fin            <= in_eop;
      end else if (verdict_valid && fin) begin
        verdict_valid  <= 1'b0;
        verdict_tunnel <= 1'b0;
        fin            <= 1'b0;
      end else if (verdict_valid && take && in_eop) begin
        fin <= 1'b1;
      end
    end
  end

endmodule

module ah_ingress_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       verdict_valid,
  input logic [1:0] verdict_code,
  input logic       verdict_tunnel
);

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> verdict_code != 2'd3);

  // R7
  tunnel_only_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_tunnel |-> (verdict_valid && verdict_code == 2'd2));

  // R8
  rise_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_valid) |-> $past(in_valid));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && $past(verdict_valid) && !$past(in_valid)) |->
      ($stable(verdict_code) && $stable(verdict_tunnel)));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!verdict_valid && !verdict_tunnel));

endmodule

bind ah_ingress_classifier ah_ingress_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .verdict_valid(verdict_valid), .verdict_code(verdict_code),
  .verdict_tunnel(verdict_tunnel)
);

// File: tb/sim_ah_ingress_classifier.sv
module sim_ah_ingress_classifier;
  localparam int RULES = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic cfg_tunnel = 1'b0;
  logic [1:0] cfg_default = 2'd0;
  logic [RULES-1:0] rule_en, rule_on_dst;
  logic [RULES*32-1:0] rule_net, rule_mask;
  logic [RULES*2-1:0] rule_act;
  logic verdict_valid, verdict_tunnel;
  logic [1:0] verdict_code;

  logic [31:0] r_net [RULES];
  logic [31:0] r_mask[RULES];
  logic [1:0]  r_act [RULES];
  logic        r_en  [RULES];
  logic        r_dst [RULES];

  always_comb
    for (int i = 0; i < RULES; i++) begin
      rule_net[i*32 +: 32] = r_net[i];
      rule_mask[i*32 +: 32] = r_mask[i];
      rule_act[i*2 +: 2] = r_act[i];
      rule_en[i] = r_en[i];
      rule_on_dst[i] = r_dst[i];
    end

  ah_ingress_classifier #(.RULES(RULES)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .cfg_tunnel(cfg_tunnel),
    .cfg_default(cfg_default), .rule_en(rule_en), .rule_on_dst(rule_on_dst),
    .rule_net(rule_net), .rule_mask(rule_mask), .rule_act(rule_act),
    .verdict_valid(verdict_valid), .verdict_code(verdict_code),
    .verdict_tunnel(verdict_tunnel));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fold(logic [1:0] a);
    return (a == 2'd3) ? 2'd0 : a;
  endfunction

  function automatic logic [1:0] model(logic [31:0] w0, logic [31:0] w2,
                                       logic [31:0] src, logic [31:0] dst);
    if (w0[31:28] != 4'd4) return 2'd0;
    if (w2[23:16] == 8'd51) return 2'd1;
    for (int i = 0; i < RULES; i++)
      if (r_en[i] && ((((r_dst[i] ? dst : src) ^ r_net[i]) & r_mask[i]) == 32'd0))
        return fold(r_act[i]);
    return fold(cfg_default);
  endfunction

  task automatic beat(logic [31:0] d, bit s, bit e, int gap);
    for (int k = 0; k < gap; k++) begin
      in_valid = 1'b0;
      @(posedge clk); #2;
    end
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    @(posedge clk); #2;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_pkt(logic [31:0] w0, logic [31:0] w2, logic [31:0] src,
                         logic [31:0] dst, int len, int maxgap, string tag);
    logic [1:0] exp;
    exp = model(w0, w2, src, dst);
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = (i == 0) ? w0 : (i == 2) ? w2 : (i == 3) ? src : (i == 4) ? dst : $urandom;
      beat(d, i == 0, i == len - 1, (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0);
      if (i < 4) check({"R8 no early valid ", tag}, verdict_valid, 1'b0);
      else begin
        check({"R8 valid ", tag}, verdict_valid, 1'b1);
        check({tag, " code"}, verdict_code, exp);
        check({"R7 tunnel ", tag}, verdict_tunnel, (exp == 2'd2) && cfg_tunnel);
      end
    end
    @(posedge clk); #2;
    check({"R8/R9 valid low after end ", tag}, verdict_valid, 1'b0);
  endtask

  function automatic logic [31:0] near(int r);
    return r_net[r] ^ ($urandom & ~r_mask[r]);
  endfunction

  function automatic logic [31:0] prefix(int n);
    return (n == 0) ? 32'd0 : (32'hFFFF_FFFF << (32 - n));
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w2, s, d;
    void'($urandom(32'd4242));
    for (int i = 0; i < RULES; i++) begin
      r_net[i] = 32'd0; r_mask[i] = 32'd0; r_act[i] = 2'd0; r_en[i] = 1'b0; r_dst[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset valid", verdict_valid, 1'b0);
    check("R11 reset tunnel", verdict_tunnel, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    r_en[0] = 1; r_dst[0] = 1; r_net[0] = 32'h0A00_0000; r_mask[0] = prefix(8);  r_act[0] = 2'd2;
    r_en[1] = 1; r_dst[1] = 0; r_net[1] = 32'h0A01_0000; r_mask[1] = prefix(16); r_act[1] = 2'd0;
    r_en[2] = 1; r_dst[2] = 1; r_net[2] = 32'hC0A8_0000; r_mask[2] = prefix(16); r_act[2] = 2'd1;
    r_en[3] = 0; r_dst[3] = 0; r_net[3] = 32'd0;         r_mask[3] = 32'd0;      r_act[3] = 2'd0;
    cfg_default = 2'd1;
    cfg_tunnel = 1'b1;

    run_pkt(32'h6500_0040, 32'h4006_0000, 32'h0101_0101, 32'h0A02_0304, 6, 0, "R1 bad version");
    check("R1 expected drop", verdict_code, 2'd0);
    run_pkt(32'h4500_0040, 32'h4033_0000, 32'h0A01_0203, 32'h0808_0808, 6, 0, "R2 already AH");
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0A01_0203, 32'h0A05_0607, 7, 0, "R4 first match");
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0A01_0203, 32'h0808_0808, 5, 0, "R3 source rule");
    run_pkt(32'h4500_0040, 32'h4011_0000, 32'h0B00_0001, 32'hAC10_0001, 8, 2, "R5 default");
    cfg_default = 2'd3;
    run_pkt(32'h4500_0040, 32'h4011_0000, 32'h0B00_0001, 32'hAC10_0001, 6, 0, "R6 default code3");
    r_act[2] = 2'd3;
    run_pkt(32'h4500_0040, 32'h4011_0000, 32'h0B00_0001, 32'hC0A8_0101, 6, 0, "R6 rule code3");
    r_act[2] = 2'd1;
    cfg_tunnel = 1'b0;
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0B00_0001, 32'h0A09_0909, 6, 1, "R7 transport");
    cfg_tunnel = 1'b1;
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0B00_0001, 32'hC0A8_0909, 6, 0, "R7 bypass no tunnel");
    r_en[3] = 1'b0; r_act[3] = 2'd2;
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0B00_0001, 32'h0C00_0001, 6, 0, "R3 disabled rule");
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0B00_0001, 32'h0A00_0001, 4, 0, "R9 truncated");

    for (int k = 0; k < 4; k++) beat($urandom, 1'b0, k == 3, 1);
    @(posedge clk); #2;
    check("R10 stray beats give no verdict", verdict_valid, 1'b0);
    run_pkt(32'h4500_0040, 32'h4006_0000, 32'h0B00_0001, 32'h0A00_0001, 9, 3, "R10 gaps and stray");

    for (int n = 0; n < 400; n++) begin
      int len, sel;
      if (n % 25 == 0) begin
        for (int i = 0; i < RULES; i++) begin
          r_en[i] = ($urandom % 4) != 0;
          r_dst[i] = $urandom % 2;
          r_net[i] = $urandom;
          r_mask[i] = prefix($urandom % 33);
          r_act[i] = $urandom % 4;
        end
        cfg_default = $urandom % 4;
      end
      cfg_tunnel = $urandom % 2;
      len = 3 + ($urandom % 10);
      w0 = (($urandom % 8) == 0) ? {4'($urandom % 16), 28'h500_0040} : 32'h4500_0040;
      w2 = {8'h40, (($urandom % 5) == 0) ? 8'd51 : 8'($urandom), 16'h0};
      sel = $urandom % RULES;
      s = (($urandom % 2) == 0) ? near(sel) : $urandom;
      sel = $urandom % RULES;
      d = (($urandom % 2) == 0) ? near(sel) : $urandom;
      run_pkt(w0, w2, s, d, len, $urandom % 3, "R3 R4 R5 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule